// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block decides whether a two-wire serial bus device has been addressed and whether it should pull the acknowledge bit low. The controller that shifts bits off the wire presents each received address byte (seven address bits followed by the read/write bit) with a one-cycle strobe. The block compares the byte against a programmed own address and, if enabled, against the general call address. It reports which of the two matched and passes the read/write bit on, so the controller can pick the slave-transmitter or slave-receiver path.

The block also answers the acknowledge question for received data bytes. One acknowledge-enable input governs the own-address, general-call and data cases together. Holding it low detaches the device from the bus, because it then neither recognises its address nor acknowledges data. Raising it again restores normal recognition.

A local configuration register holds the own address in its upper seven bits and the general-call enable in bit 0. It is loaded through a write strobe. All results are registered and appear as one-cycle pulses in the cycle after the strobe that caused them.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the configuration register holds 0xFE, which gives own address 0x7F with general call disabled. All outputs are low in the first cycle after reset.
- R2: An address strobe whose byte bits [7:1] equal the own address, with acknowledge-enable high, gives a one-cycle pulse in the next cycle with match_o=1, own_hit_o=1, ack_o=1 and rw_o equal to byte bit 0.
- R3: An address strobe whose byte matches neither the own address nor the general call gives all outputs low in the next cycle.
- R4: With general-call enable (configuration bit 0) set, the byte 0x00 gives match_o=1, gc_hit_o=1, ack_o=1 and rw_o=0 in the next cycle. With it clear, 0x00 is not a general call. The own-address and general-call flags are evaluated independently, so both can be set at once when the own address is 0.
- R5: A byte with address bits all zero and read/write bit 1 (0x01) is never a general call.
- R6: A data strobe with acknowledge-enable high gives ack_o=1 and match_o=0 in the next cycle when mode_i is master-receive (2) or slave-receive (4).
- R7: A data strobe in mode idle (0), master-transmit (1) or slave-transmit (3) gives ack_o=0.
- R8: With acknowledge-enable low, neither address strobes nor data strobes raise match_o or ack_o. Raising acknowledge-enable again restores matching.
- R9: When an address strobe and a data strobe arrive in the same cycle, the data strobe is ignored and only the address result is produced.
- R10: A configuration write applies to strobes in later cycles. A strobe in the same cycle as the write is compared against the old value.
- R11: The outputs are low in any cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Own address in [7:1], general-call enable in [0] |
| ack_en_i | input | 1 | Acknowledge enable |
| mode_i | input | 3 | Controller mode: 0 idle, 1 master-tx, 2 master-rx, 3 slave-tx, 4 slave-rx |
| addr_stb_i | input | 1 | Address byte received strobe |
| data_stb_i | input | 1 | Data byte received strobe |
| rx_byte_i | input | 8 | Received byte, read/write bit in [0] |
| match_o | output | 1 | Device addressed (pulse) |
| own_hit_o | output | 1 | Own address matched |
| gc_hit_o | output | 1 | General call matched |
| rw_o | output | 1 | Read/write bit of the matched address |
| ack_o | output | 1 | Drive acknowledge for this byte |

## Verification
Every result leaves a single register stage, so each one is due in the cycle right after the strobe that caused it. No strobe may ever produce an output two cycles later. The driver applies one stimulus per cycle on the falling edge and enqueues exactly one expected result, idle cycles included. The monitor takes one entry after each rising edge, once the output register has settled. Because the expected results and the output pulses advance together, a result that arrives a cycle early or a cycle late shows up as a mismatch.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE = 3'd0,
        MODE_MTX  = 3'd1,
        MODE_MRX  = 3'd2,
        MODE_STX  = 3'd3,
        MODE_SRX  = 3'd4
    } am_mode_e;

    typedef struct packed {
        logic own;
        logic gc;
    } am_hit_t;

    typedef struct packed {
        logic match;
        logic own;
        logic gc;
        logic rw;
        logic ack;
    } am_result_t;

    localparam am_result_t AM_RESULT_NONE = '{match: 1'b0, own: 1'b0, gc: 1'b0, rw: 1'b0, ack: 1'b0};

    function automatic logic is_rx_mode(am_mode_e m);
        return (m == MODE_MRX) || (m == MODE_SRX);
    endfunction

endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg #(
    parameter int          ADDR_W  = 7,
    parameter logic [ADDR_W-1:0] RST_OWN = '1,
    parameter logic        RST_GCE = 1'b0,
    localparam int         BYTE_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0] own_q,
    output logic              gce_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= RST_OWN;
            gce_q <= RST_GCE;
        end else if (we) begin
            own_q <= wdata[BYTE_W-1:1];
            gce_q <= wdata[0];
        end
    end

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
#(
    parameter int  ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gce,
    output am_hit_t           hit
);

    logic [ADDR_W-1:0] eq_bit;
    logic [ADDR_W-1:0] zero_bit;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign eq_bit[i]   = ~(rx_byte[i+1] ^ own_addr[i]);
        assign zero_bit[i] = ~rx_byte[i+1];
    end

    always_comb begin
        hit.own = &eq_bit;
        hit.gc  = gce & (&zero_bit) & ~rx_byte[0];
    end

endmodule

// File: rtl/i2c_am_ack.sv
module i2c_am_ack
    import i2c_am_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_stb,
    input  logic       data_stb,
    input  logic       ack_en,
    input  am_mode_e   mode,
    input  am_hit_t    hit,
    input  logic       rw,
    output am_result_t res_q
);

    am_result_t res_d;

    always_comb begin
        res_d = AM_RESULT_NONE;
        if (addr_stb) begin
            if (ack_en && (hit.own || hit.gc)) begin
                res_d.match = 1'b1;
                res_d.own   = hit.own;
                res_d.gc    = hit.gc;
                res_d.rw    = rw;
                res_d.ack   = 1'b1;
            end
        end else if (data_stb) begin
            res_d.ack = ack_en && is_rx_mode(mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= AM_RESULT_NONE;
        else     res_q <= res_d;
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int  ADDR_W  = 7,
    parameter logic [ADDR_W-1:0] RST_OWN = '1,
    parameter logic RST_GCE = 1'b0,
    localparam int BYTE_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              ack_en_i,
    input  logic [2:0]        mode_i,
    input  logic              addr_stb_i,
    input  logic              data_stb_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    output logic              match_o,
    output logic              own_hit_o,
    output logic              gc_hit_o,
    output logic              rw_o,
    output logic              ack_o
);

    logic [ADDR_W-1:0] own_q;
    logic              gce_q;
    am_hit_t           hit;
    am_result_t        res_q;

    i2c_am_cfg #(
        .ADDR_W (ADDR_W),
        .RST_OWN(RST_OWN),
        .RST_GCE(RST_GCE)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wdata(cfg_wdata),
        .own_q(own_q),
        .gce_q(gce_q)
    );

    i2c_am_cmp #(
        .ADDR_W(ADDR_W)
    ) u_cmp (
        .rx_byte (rx_byte_i),
        .own_addr(own_q),
        .gce     (gce_q),
        .hit     (hit)
    );

    i2c_am_ack u_ack (
        .clk     (clk),
        .rst     (rst),
        .addr_stb(addr_stb_i),
        .data_stb(data_stb_i),
        .ack_en  (ack_en_i),
        .mode    (am_mode_e'(mode_i)),
        .hit     (hit),
        .rw      (rx_byte_i[0]),
        .res_q   (res_q)
    );

    assign match_o   = res_q.match;
    assign own_hit_o = res_q.own;
    assign gc_hit_o  = res_q.gc;
    assign rw_o      = res_q.rw;
    assign ack_o     = res_q.ack;

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_en_i,
    input logic [2:0]        mode_i,
    input logic              addr_stb_i,
    input logic              data_stb_i,
    input logic [BYTE_W-1:0] rx_byte_i,
    input logic              match_o,
    input logic              own_hit_o,
    input logic              gc_hit_o,
    input logic              rw_o,
    input logic              ack_o
);

    logic rx_mode;
    assign rx_mode = (mode_i == 3'd2) || (mode_i == 3'd4);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!match_o && !ack_o && !own_hit_o && !gc_hit_o && !rw_o));

    // R2, R4: a match always names its source
    a_r2_match_has_source: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (own_hit_o || gc_hit_o) && ack_o);

    // R4, R5: general call only for an all-zero byte
    a_r5_gc_needs_zero: assert property (@(posedge clk) disable iff (rst)
        (addr_stb_i && rx_byte_i != '0) |=> !gc_hit_o);

    // R6
    a_r6_data_ack: assert property (@(posedge clk) disable iff (rst)
        (data_stb_i && !addr_stb_i && ack_en_i && rx_mode) |=> (ack_o && !match_o));

    // R7
    a_r7_no_ack_tx: assert property (@(posedge clk) disable iff (rst)
        (data_stb_i && !addr_stb_i && !rx_mode) |=> !ack_o);

    // R8
    a_r8_disconnected: assert property (@(posedge clk) disable iff (rst)
        !ack_en_i |=> (!ack_o && !match_o));

    // R11
    a_r11_no_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
        (!addr_stb_i && !data_stb_i) |=> (!ack_o && !match_o && !rw_o));

    // R2: read/write bit only travels with a match
    a_r2_rw_with_match: assert property (@(posedge clk) disable iff (rst)
        rw_o |-> match_o);

endmodule

bind i2c_addr_match i2c_addr_match_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_en_i  (ack_en_i),
    .mode_i    (mode_i),
    .addr_stb_i(addr_stb_i),
    .data_stb_i(data_stb_i),
    .rx_byte_i (rx_byte_i),
    .match_o   (match_o),
    .own_hit_o (own_hit_o),
    .gc_hit_o  (gc_hit_o),
    .rw_o      (rw_o),
    .ack_o     (ack_o)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

    typedef struct {
        logic [4:0] v;   // match, own, gc, rw, ack
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       ack_en_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic       addr_stb_i = 1'b0;
    logic       data_stb_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       match_o, own_hit_o, gc_hit_o, rw_o, ack_o;

    int errors = 0;
    int checks = 0;
    exp_t q[$];
    logic [6:0] b_own = 7'h7F;
    logic       b_gce = 1'b0;

    always #10 clk = ~clk;

    i2c_addr_match u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ack_en_i  (ack_en_i),
        .mode_i    (mode_i),
        .addr_stb_i(addr_stb_i),
        .data_stb_i(data_stb_i),
        .rx_byte_i (rx_byte_i),
        .match_o   (match_o),
        .own_hit_o (own_hit_o),
        .gc_hit_o  (gc_hit_o),
        .rw_o      (rw_o),
        .ack_o     (ack_o)
    );

    function automatic logic [4:0] model(logic we_unused, logic ae, logic [2:0] md,
                                         logic as, logic ds, logic [7:0] b);
        logic own, gc;
        own = (b[7:1] == b_own);
        gc  = b_gce && (b == 8'h00);
        if (as) begin
            if (ae && (own || gc)) return {1'b1, own, gc, b[0], 1'b1};
            return 5'b0;
        end
        if (ds) return {4'b0, ae && (md == 3'd2 || md == 3'd4)};
        return 5'b0;
    endfunction

    task automatic step(input logic we, input logic [7:0] wd, input logic ae,
                        input logic [2:0] md, input logic as, input logic ds,
                        input logic [7:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; ack_en_i = ae; mode_i = md;
        addr_stb_i = as; data_stb_i = ds; rx_byte_i = b;
        e.v = model(we, ae, md, as, ds, b);
        e.tag = tag;
        q.push_back(e);
        if (we) begin
            b_own = wd[7:1];
            b_gce = wd[0];
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic adr(input logic [7:0] b, input logic ae, input string tag);
        step(1'b0, 8'h00, ae, 3'd4, 1'b1, 1'b0, b, tag);
    endtask

    task automatic dat(input logic [2:0] md, input logic ae, input string tag);
        step(1'b0, 8'h00, ae, md, 1'b0, 1'b1, 8'h5A, tag);
    endtask

    // monitor: one expected item per cycle, compared after the output register updates
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e = q.pop_front();
                act = {match_o, own_hit_o, gc_hit_o, rw_o, ack_o};
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s: {match,own,gc,rw,ack} actual=%b expected=%b", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        checks++;
        if ({match_o, own_hit_o, gc_hit_o, rw_o, ack_o} !== 5'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual=%b expected=00000",
                     {match_o, own_hit_o, gc_hit_o, rw_o, ack_o});
        end

        // R1/R2: reset address 0x7F, write and read
        adr(8'hFE, 1'b1, "R1 R2 reset own addr write");
        adr(8'hFF, 1'b1, "R2 own addr read rw=1");
        idle("R11 idle after match");
        adr(8'h00, 1'b1, "R4 gc disabled at reset");
        adr(8'hA0, 1'b1, "R3 mismatch");
        adr(8'h7E, 1'b1, "R3 near miss");

        // R10: load own 0x2A, strobe same cycle uses old address
        step(1'b1, 8'h54, 1'b1, 3'd4, 1'b1, 1'b0, 8'hFE, "R10 same-cycle load uses old");
        adr(8'h55, 1'b1, "R10 new addr read");
        adr(8'hFE, 1'b1, "R10 old addr gone");
        step(1'b1, 8'h55, 1'b1, 3'd4, 1'b1, 1'b0, 8'h00, "R10 gce load not yet active");
        adr(8'h00, 1'b1, "R4 general call");
        adr(8'h01, 1'b1, "R5 gc with read bit");
        adr(8'h54, 1'b1, "R2 own addr after gce");

        // R6/R7 data acknowledge per mode
        dat(3'd2, 1'b1, "R6 master rx data ack");
        dat(3'd4, 1'b1, "R6 slave rx data ack");
        dat(3'd0, 1'b1, "R7 idle mode no ack");
        dat(3'd1, 1'b1, "R7 master tx no ack");
        dat(3'd3, 1'b1, "R7 slave tx no ack");

        // R8 disconnect and resume
        adr(8'h54, 1'b0, "R8 own addr ignored");
        adr(8'h00, 1'b0, "R8 gc ignored");
        dat(3'd4, 1'b0, "R8 data not acked");
        dat(3'd2, 1'b0, "R8 data not acked mrx");
        adr(8'h54, 1'b1, "R8 resume own addr");

        // R9 simultaneous strobes
        step(1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 1'b1, 8'hA0, "R9 data ignored on mismatch");
        step(1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 1'b1, 8'h55, "R9 address wins");
        idle("R11 idle");

        // R4 own address zero with gc: both flags
        step(1'b1, 8'h01, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, "R11 load cycle idle");
        adr(8'h00, 1'b1, "R4 own zero and gc together");
        adr(8'h01, 1'b1, "R5 own zero read no gc");
        step(1'b1, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, "R11 load cycle idle");
        adr(8'h02, 1'b1, "R3 mismatch own zero");
        idle("R11 final idle");
        idle("R11 final idle");

        wait (q.size() == 0);
        @(posedge clk); #5;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule